// File: doc/BRIEF.md
# Byte-to-Word Data FIFO Engine

This block sits between a byte-wide card data port and a 16-entry FIFO of 32-bit words, and moves data in one direction at a time. In receive mode it gathers bytes arriving from the card into words and pushes them into the FIFO; software then drains the FIFO through a bus pop port. In transmit mode software fills the FIFO through a bus push port, and the engine pops words and hands their bytes to the card one at a time.

Software programs a transfer length and then writes the control word with the enable bit set. That write loads a down-counter of remaining bytes. The counter drops by one for every byte that crosses the card handshake. The engine switches itself off once the counter is zero and the FIFO is empty. Direction-gated fill-level flags and a few sticky event flags report progress.

Top module: `xfer_pack_engine`

## Requirements
- R1: After reset the engine is disabled, the direction is transmit, the remaining byte count is 0, the FIFO is empty, and data_end, block_end, err_overrun and err_underrun are all 0.
- R2: A control write with ctl_en=1 loads bytes_left from the most recently written 16-bit length and clears all four sticky flags. ctl_dir_rx=1 selects receive and 0 selects transmit.
- R3: In receive mode card_rx_ready is high only while the engine is enabled, bytes_left is nonzero and the FIFO is not full. Each accepted byte lowers bytes_left by exactly one.
- R4: Received bytes are packed little-endian: byte k (0..3) of a word lands in bits 8k+7:8k, and the word is pushed as its fourth byte is accepted.
- R5: When bytes_left reaches zero in receive mode, a partly filled word is pushed at once, with its unfilled upper bytes set to zero.
- R6: In transmit mode bytes go out in little-endian order from the word being unpacked. The next FIFO word is popped only after all four bytes of the current one have been sent, and the bytes of the final word beyond the count are dropped.
- R7: In receive mode bus_push has no effect on the FIFO. In transmit mode bus_pop has no effect on the FIFO.
- R8: A transmit-mode bus_push while the FIFO holds 16 words leaves the contents unchanged and sets err_overrun. A receive-mode bus_pop while the FIFO is empty leaves it empty and sets err_underrun. Both flags stay set until the next enabling control write.
- R9: While enabled, the engine clears its own enable one cycle after bytes_left is zero and the FIFO is empty. It stays enabled while the FIFO still holds words.
- R10: data_end and block_end are set together when the engine is enabled with bytes_left at zero.
- R11: rx_flags and tx_flags use the bit layout [4] active (enabled and bytes_left nonzero), [3] half (receive: count ≥ 8; transmit: count ≤ 8), [2] full (count 16), [1] empty (count 0) and [0] data available (count nonzero). Only the vector for the selected direction is driven; the other reads all zeros.
- R12: words_left always equals (bytes_left + 3) >> 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_wr | input | 1 | Strobe that captures len_val as the transfer length |
| len_val | input | LEN_W | Transfer length in bytes |
| ctl_wr | input | 1 | Strobe that writes the control fields |
| ctl_en | input | 1 | Enable bit of the control write |
| ctl_dir_rx | input | 1 | Direction: 1 receive, 0 transmit |
| bus_push | input | 1 | Bus push of one word into the FIFO |
| bus_wdata | input | WORD_W | Word pushed by the bus |
| bus_pop | input | 1 | Bus pop of the FIFO head |
| bus_rdata | output | WORD_W | Current FIFO head word |
| card_rx_valid | input | 1 | Card offers a received byte |
| card_rx_byte | input | BYTE_W | Received byte |
| card_rx_ready | output | 1 | Engine accepts the offered byte |
| card_tx_valid | output | 1 | Engine offers a byte to send |
| card_tx_byte | output | BYTE_W | Byte to send |
| card_tx_ready | input | 1 | Card takes the offered byte |
| eng_en | output | 1 | Engine enable state |
| bytes_left | output | LEN_W | Remaining byte count |
| words_left | output | LEN_W | Remaining count rounded up to words |
| rx_flags | output | 5 | Receive-side fill flags |
| tx_flags | output | 5 | Transmit-side fill flags |
| data_end | output | 1 | Sticky: count reached zero |
| block_end | output | 1 | Sticky: block finished |
| err_overrun | output | 1 | Sticky: push into a full FIFO |
| err_underrun | output | 1 | Sticky: pop from an empty FIFO |

## Verification
The bench runs receive transfers whose lengths are not multiples of four and checks that the last word carries zeros above the final byte. A packer that failed to flush, or that left stale bytes in the upper lanes, would return a short or corrupted last word. In transmit mode it holds the card back and watches the FIFO level: an unpacker that prefetched early would drop the count before the fourth byte went out, and a byte-order slip shows up as swapped bytes. Full and empty boundaries are driven from both bus ports to catch lost words, missing sticky errors and half flags off by one at a count of 8. Self-shutdown is probed with a zero length and with words left unread in the FIFO.

// File: rtl/xfer_pack_pkg.sv
package xfer_pack_pkg;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } xfer_dir_e;

   // bit layout shared by both flag vectors
   typedef struct packed {
      logic active;
      logic half;
      logic full;
      logic empty;
      logic avail;
   } side_flags_t;

endpackage

// File: rtl/xpe_word_fifo.sv
module xpe_word_fifo #(
   parameter int DEPTH       = 16,
   parameter int WIDTH       = 32,
   parameter bit CLEAR_STORE = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [WIDTH-1:0]           push_data,
   input  logic                       pop,
   output logic [WIDTH-1:0]           head,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("xpe_word_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    rd_ptr;
   logic [AW-1:0]    wr_idx;
   logic             do_push;
   logic             do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign wr_idx  = rd_ptr + count[AW-1:0];
   assign head    = mem[rd_ptr];

   if (CLEAR_STORE) begin : g_store_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (do_push) begin
            mem[wr_idx] <= push_data;
         end
      end
   end else begin : g_store_plain
      always_ff @(posedge clk) begin
         if (do_push) mem[wr_idx] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_pop) rd_ptr <= rd_ptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/xpe_rx_packer.sv
module xpe_rx_packer #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic              last,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              push,
   output logic [WORD_W-1:0] word_out
);
   localparam int LANES = WORD_W / BYTE_W;
   localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1;

   if (LANES < 2 || LANES * BYTE_W != WORD_W) begin : g_bad_lanes
      $error("xpe_rx_packer: WORD_W must hold at least two whole bytes");
   end

   logic [WORD_W-1:0] acc_q;
   logic [IW-1:0]     idx_q;
   logic [WORD_W-1:0] merged;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*BYTE_W +: BYTE_W] =
         (idx_q == IW'(l)) ? byte_in : acc_q[l*BYTE_W +: BYTE_W];
   end

   assign push     = take && ((idx_q == IW'(LANES - 1)) || last);
   assign word_out = merged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         idx_q <= '0;
      end else if (clr || push) begin
         acc_q <= '0;
         idx_q <= '0;
      end else if (take) begin
         acc_q <= merged;
         idx_q <= idx_q + IW'(1);
      end
   end

endmodule

// File: rtl/xpe_tx_unpacker.sv
module xpe_tx_unpacker #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              allow,
   input  logic              fifo_empty,
   input  logic [WORD_W-1:0] fifo_head,
   output logic              pop,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_out,
   input  logic              take
);
   localparam int LANES = WORD_W / BYTE_W;
   localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1;

   logic [WORD_W-1:0] word_q;
   logic [IW-1:0]     idx_q;
   logic              have_q;
   logic [BYTE_W-1:0] lane [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane[l] = word_q[l*BYTE_W +: BYTE_W];
   end

   assign pop        = allow && !have_q && !fifo_empty;
   assign byte_valid = allow && have_q;
   assign byte_out   = lane[idx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         idx_q  <= '0;
         have_q <= 1'b0;
      end else if (clr) begin
         idx_q  <= '0;
         have_q <= 1'b0;
      end else if (pop) begin
         word_q <= fifo_head;
         idx_q  <= '0;
         have_q <= 1'b1;
      end else if (take) begin
         idx_q <= idx_q + IW'(1);
         if (idx_q == IW'(LANES - 1)) have_q <= 1'b0;
      end
   end

endmodule

// File: rtl/xpe_status.sv
module xpe_status
   import xfer_pack_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input  logic          run,
   input  xfer_dir_e     dir,
   input  logic [CW-1:0] count,
   output side_flags_t   rx_fl,
   output side_flags_t   tx_fl
);
   localparam int HALF = DEPTH / 2;

   side_flags_t base_rx;
   side_flags_t base_tx;

   always_comb begin
      base_rx.active = run;
      base_rx.half   = (count >= CW'(HALF));
      base_rx.full   = (count == CW'(DEPTH));
      base_rx.empty  = (count == '0);
      base_rx.avail  = (count != '0);
      base_tx        = base_rx;
      base_tx.half   = (count <= CW'(HALF));
   end

   assign rx_fl = (dir == DIR_RX) ? base_rx : '0;
   assign tx_fl = (dir == DIR_TX) ? base_tx : '0;

endmodule

// File: rtl/xfer_pack_engine.sv
module xfer_pack_engine
   import xfer_pack_pkg::*;
#(
   parameter int FIFO_DEPTH  = 16,
   parameter int WORD_W      = 32,
   parameter int BYTE_W      = 8,
   parameter int LEN_W       = 16,
   parameter bit CLEAR_STORE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              len_wr,
   input  logic [LEN_W-1:0]  len_val,
   input  logic              ctl_wr,
   input  logic              ctl_en,
   input  logic              ctl_dir_rx,
   input  logic              bus_push,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic              bus_pop,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic              card_rx_valid,
   input  logic [BYTE_W-1:0] card_rx_byte,
   output logic              card_rx_ready,
   output logic              card_tx_valid,
   output logic [BYTE_W-1:0] card_tx_byte,
   input  logic              card_tx_ready,
   output logic              eng_en,
   output logic [LEN_W-1:0]  bytes_left,
   output logic [LEN_W-1:0]  words_left,
   output logic [4:0]        rx_flags,
   output logic [4:0]        tx_flags,
   output logic              data_end,
   output logic              block_end,
   output logic              err_overrun,
   output logic              err_underrun
);
   localparam int LANES = WORD_W / BYTE_W;
   localparam int LSH   = $clog2(LANES);
   localparam int CW    = $clog2(FIFO_DEPTH) + 1;

   if ((1 << LSH) != LANES) begin : g_bad_lanes
      $error("xfer_pack_engine: bytes per word must be a power of two");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("xfer_pack_engine: LEN_W too small");
   end

   xfer_dir_e         dir_q;
   logic              en_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  cnt_q;
   logic              cnt_nz;
   logic              rx_mode;
   logic              start;

   logic              f_push, f_pop, f_full, f_empty;
   logic [WORD_W-1:0] f_wdata, f_head;
   logic [CW-1:0]     f_count;

   logic              rx_take, pk_push;
   logic [WORD_W-1:0] pk_word;
   logic              tx_allow, tx_take, up_pop;

   side_flags_t       rx_fl, tx_fl;
   logic [LEN_W:0]    round_up;

   assign rx_mode  = (dir_q == DIR_RX);
   assign cnt_nz   = (cnt_q != '0);
   assign start    = ctl_wr && ctl_en;

   assign card_rx_ready = en_q && rx_mode && cnt_nz && !f_full;
   assign rx_take       = card_rx_valid && card_rx_ready;
   assign tx_allow      = en_q && !rx_mode && cnt_nz;
   assign tx_take       = card_tx_valid && card_tx_ready;

   // bus and engine each own one FIFO port, chosen by direction
   assign f_push  = rx_mode ? pk_push : bus_push;
   assign f_wdata = rx_mode ? pk_word : bus_wdata;
   assign f_pop   = rx_mode ? bus_pop : up_pop;

   xpe_word_fifo #(
      .DEPTH      (FIFO_DEPTH),
      .WIDTH      (WORD_W),
      .CLEAR_STORE(CLEAR_STORE)
   ) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (f_push),
      .push_data(f_wdata),
      .pop      (f_pop),
      .head     (f_head),
      .count    (f_count),
      .full     (f_full),
      .empty    (f_empty)
   );

   xpe_rx_packer #(
      .WORD_W(WORD_W),
      .BYTE_W(BYTE_W)
   ) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ctl_wr),
      .take    (rx_take),
      .last    (cnt_q == LEN_W'(1)),
      .byte_in (card_rx_byte),
      .push    (pk_push),
      .word_out(pk_word)
   );

   xpe_tx_unpacker #(
      .WORD_W(WORD_W),
      .BYTE_W(BYTE_W)
   ) u_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ctl_wr),
      .allow     (tx_allow),
      .fifo_empty(f_empty),
      .fifo_head (f_head),
      .pop       (up_pop),
      .byte_valid(card_tx_valid),
      .byte_out  (card_tx_byte),
      .take      (tx_take)
   );

   xpe_status #(
      .DEPTH(FIFO_DEPTH),
      .CW   (CW)
   ) u_stat (
      .run  (en_q && cnt_nz),
      .dir  (dir_q),
      .count(f_count),
      .rx_fl(rx_fl),
      .tx_fl(tx_fl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
      end else if (len_wr) begin
         len_q <= len_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= DIR_TX;
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (ctl_wr) begin
            dir_q <= xfer_dir_e'(ctl_dir_rx);
            en_q  <= ctl_en;
         end else if (en_q && !cnt_nz && f_empty) begin
            en_q <= 1'b0;
         end
         if (start) begin
            cnt_q <= len_q;
         end else if (rx_take || tx_take) begin
            cnt_q <= cnt_q - LEN_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_end     <= 1'b0;
         block_end    <= 1'b0;
         err_overrun  <= 1'b0;
         err_underrun <= 1'b0;
      end else if (start) begin
         data_end     <= 1'b0;
         block_end    <= 1'b0;
         err_overrun  <= 1'b0;
         err_underrun <= 1'b0;
      end else begin
         if (en_q && !cnt_nz) begin
            data_end  <= 1'b1;
            block_end <= 1'b1;
         end
         if (!rx_mode && bus_push && f_full) err_overrun  <= 1'b1;
         if (rx_mode && bus_pop && f_empty)  err_underrun <= 1'b1;
      end
   end

   assign round_up   = {1'b0, cnt_q} + (LEN_W + 1)'(LANES - 1);
   assign words_left = LEN_W'(round_up >> LSH);
   assign bytes_left = cnt_q;
   assign eng_en     = en_q;
   assign bus_rdata  = f_head;
   assign rx_flags   = rx_fl;
   assign tx_flags   = tx_fl;

endmodule

// File: rtl/xpe_checker.sv
module xpe_checker #(
   parameter int LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic             bus_push,
   input logic             bus_pop,
   input logic             card_rx_valid,
   input logic             card_rx_ready,
   input logic             card_tx_valid,
   input logic             card_tx_ready,
   input logic             eng_en,
   input logic [LEN_W-1:0] bytes_left,
   input logic [4:0]       rx_flags,
   input logic [4:0]       tx_flags,
   input logic             data_end,
   input logic             block_end,
   input logic             err_overrun,
   input logic             err_underrun
);
   logic rx_hs, tx_hs;
   assign rx_hs = card_rx_valid && card_rx_ready;
   assign tx_hs = card_tx_valid && card_tx_ready;

   // R3
   ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_rx_ready |-> (eng_en && bytes_left != '0));

   // R6
   tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_tx_valid |-> (eng_en && bytes_left != '0 && !card_rx_ready));

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_hs || tx_hs) && !ctl_wr) |=> (bytes_left == $past(bytes_left) - LEN_W'(1)));

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_hs && !tx_hs && !ctl_wr) |=> $stable(bytes_left));

   // R9
   stay_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_en && !ctl_wr && bytes_left != '0) |=> eng_en);

   // R10
   end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_en && !ctl_wr && bytes_left == '0) |=> (data_end && block_end));

   // R8
   overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_wr && bus_push && tx_flags[2]) |=> err_overrun);

   // R8
   underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_wr && bus_pop && rx_flags[1]) |=> err_underrun);

   // R11
   side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flags == '0) || (tx_flags == '0));

   // R11
   fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_flags[2], rx_flags[1]}) && $onehot0({tx_flags[2], tx_flags[1]}));

endmodule

bind xfer_pack_engine xpe_checker #(.LEN_W(LEN_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_wr       (ctl_wr),
   .bus_push     (bus_push),
   .bus_pop      (bus_pop),
   .card_rx_valid(card_rx_valid),
   .card_rx_ready(card_rx_ready),
   .card_tx_valid(card_tx_valid),
   .card_tx_ready(card_tx_ready),
   .eng_en       (eng_en),
   .bytes_left   (bytes_left),
   .rx_flags     (rx_flags),
   .tx_flags     (tx_flags),
   .data_end     (data_end),
   .block_end    (block_end),
   .err_overrun  (err_overrun),
   .err_underrun (err_underrun)
);

// File: tb/xfer_pack_engine_tb_top.sv
`timescale 1ns/1ps
module xfer_pack_engine_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        len_wr = 1'b0;
   logic [15:0] len_val = '0;
   logic        ctl_wr = 1'b0, ctl_en = 1'b0, ctl_dir_rx = 1'b0;
   logic        bus_push = 1'b0, bus_pop = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        card_rx_valid = 1'b0;
   logic [7:0]  card_rx_byte = '0;
   logic        card_rx_ready;
   logic        card_tx_valid;
   logic [7:0]  card_tx_byte;
   logic        card_tx_ready = 1'b0;
   logic        eng_en;
   logic [15:0] bytes_left, words_left;
   logic [4:0]  rx_flags, tx_flags;
   logic        data_end, block_end, err_overrun, err_underrun;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   xfer_pack_engine dut_i (
      .clk(clk), .rst_n(rst_n),
      .len_wr(len_wr), .len_val(len_val),
      .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_dir_rx(ctl_dir_rx),
      .bus_push(bus_push), .bus_wdata(bus_wdata),
      .bus_pop(bus_pop), .bus_rdata(bus_rdata),
      .card_rx_valid(card_rx_valid), .card_rx_byte(card_rx_byte),
      .card_rx_ready(card_rx_ready),
      .card_tx_valid(card_tx_valid), .card_tx_byte(card_tx_byte),
      .card_tx_ready(card_tx_ready),
      .eng_en(eng_en), .bytes_left(bytes_left), .words_left(words_left),
      .rx_flags(rx_flags), .tx_flags(tx_flags),
      .data_end(data_end), .block_end(block_end),
      .err_overrun(err_overrun), .err_underrun(err_underrun)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_flags(input int cnt, input bit act, input bit rx);
      return {act, rx ? (cnt >= 8) : (cnt <= 8), cnt == 16, cnt == 0, cnt != 0};
   endfunction

   task automatic wr_len(input int v);
      @(negedge clk); len_wr = 1'b1; len_val = 16'(v);
      @(negedge clk); len_wr = 1'b0;
   endtask

   task automatic wr_ctl(input bit en, input bit rx);
      @(negedge clk); ctl_wr = 1'b1; ctl_en = en; ctl_dir_rx = rx;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic push_w(input logic [31:0] w);
      @(negedge clk); bus_push = 1'b1; bus_wdata = w;
      @(negedge clk); bus_push = 1'b0;
   endtask

   task automatic pop_w(output logic [31:0] w);
      @(negedge clk); bus_pop = 1'b1; #1 w = bus_rdata;
      @(negedge clk); bus_pop = 1'b0;
   endtask

   task automatic tx_pulse(output logic [7:0] b, output bit got);
      @(negedge clk); card_tx_ready = 1'b1; #1;
      got = card_tx_valid; b = card_tx_byte;
      @(negedge clk); card_tx_ready = 1'b0;
   endtask

   // receive run with random gaps; checks packing, flush, end flags, idle
   task automatic run_rx(input int len, input int gap);
      logic [7:0]  bytes [64];
      logic [31:0] w, e;
      int idx, nw;
      for (int i = 0; i < len; i++) bytes[i] = 8'($urandom);
      wr_len(len);
      wr_ctl(1'b1, 1'b1);
      chk("R2 load", 32'(bytes_left), 32'(len));
      idx = 0;
      while (idx < len) begin
         @(negedge clk);
         chk("R3 count", 32'(bytes_left), 32'(len - idx));
         chk("R12 words", 32'(words_left), 32'((len - idx + 3) >> 2));
         card_rx_valid = (($urandom % 100) >= gap);
         card_rx_byte  = bytes[idx];
         #1;
         if (card_rx_valid && card_rx_ready) idx++;
      end
      @(negedge clk); card_rx_valid = 1'b0;
      chk("R3 zero", 32'(bytes_left), 32'd0);
      chk("R3 ready", 32'(card_rx_ready), 32'd0);
      @(negedge clk);
      nw = (len + 3) / 4;
      chk("R10 data_end", 32'(data_end), 32'd1);
      chk("R10 block_end", 32'(block_end), 32'd1);
      chk("R9 hold", 32'(eng_en), 32'd1);
      chk("R11 rx level", 32'(rx_flags), 32'(exp_flags(nw, 1'b0, 1'b1)));
      for (int j = 0; j < nw; j++) begin
         e = '0;
         for (int k = 0; k < 4; k++)
            if (4 * j + k < len) e[8*k +: 8] = bytes[4*j + k];
         pop_w(w);
         chk((4 * j + 4 > len) ? "R5 partial" : "R4 packed", w, e);
      end
      @(negedge clk);
      chk("R9 idle", 32'(eng_en), 32'd0);
   endtask

   // transmit run with random card stalls; checks byte order and idle
   task automatic run_tx(input int len, input int gap);
      logic [31:0] words [16];
      int nw, got;
      nw = (len + 3) / 4;
      wr_ctl(1'b0, 1'b0);
      wr_len(len);
      for (int j = 0; j < nw; j++) begin
         words[j] = $urandom;
         push_w(words[j]);
      end
      wr_ctl(1'b1, 1'b0);
      got = 0;
      while (got < len) begin
         @(negedge clk);
         chk("R12 words", 32'(words_left), 32'((len - got + 3) >> 2));
         card_tx_ready = (($urandom % 100) >= gap);
         #1;
         if (card_tx_valid && card_tx_ready) begin
            chk("R6 byte", 32'(card_tx_byte), 32'(words[got/4][8*(got%4) +: 8]));
            got++;
         end
      end
      @(negedge clk); card_tx_ready = 1'b0;
      #1 chk("R6 drop", 32'(card_tx_valid), 32'd0);
      @(negedge clk);
      chk("R9 idle", 32'(eng_en), 32'd0);
      chk("R10 data_end", 32'(data_end), 32'd1);
      chk("R11 tx idle", 32'(tx_flags), 32'(exp_flags(0, 1'b0, 1'b0)));
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] w, ref_w [16];
      logic [7:0]  b;
      bit          g;
      void'($urandom(32'h5eed1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 en", 32'(eng_en), 32'd0);
      chk("R1 count", 32'(bytes_left), 32'd0);
      chk("R1 tx flags", 32'(tx_flags), 32'(exp_flags(0, 1'b0, 1'b0)));
      chk("R1 rx flags", 32'(rx_flags), 32'd0);
      chk("R1 sticky", 32'({data_end, block_end, err_overrun, err_underrun}), 32'd0);

      // R11 half boundaries on the transmit side
      for (int i = 0; i < 9; i++) begin
         push_w(32'(i));
         if (i >= 6) chk("R11 tx half", 32'(tx_flags), 32'(exp_flags(i + 1, 1'b0, 1'b0)));
      end
      // R7 a transmit-mode pop leaves the FIFO alone
      pop_w(w);
      chk("R7 tx pop ignored", 32'(tx_flags), 32'(exp_flags(9, 1'b0, 1'b0)));
      wr_ctl(1'b0, 1'b1);
      chk("R11 rx half 9", 32'(rx_flags), 32'(exp_flags(9, 1'b0, 1'b1)));
      chk("R11 gated", 32'(tx_flags), 32'd0);
      for (int i = 0; i < 9; i++) begin
         pop_w(w);
         chk("R7 fifo order", w, 32'(i));
         if (i < 2) chk("R11 rx half", 32'(rx_flags), 32'(exp_flags(8 - i, 1'b0, 1'b1)));
      end
      // R8 underrun, R7 receive-mode push ignored
      pop_w(w);
      chk("R8 underrun", 32'(err_underrun), 32'd1);
      chk("R8 still empty", 32'(rx_flags), 32'(exp_flags(0, 1'b0, 1'b1)));
      push_w(32'hdead_beef);
      chk("R7 rx push ignored", 32'(rx_flags), 32'(exp_flags(0, 1'b0, 1'b1)));

      // R8 overrun on a full FIFO
      wr_ctl(1'b0, 1'b0);
      for (int i = 0; i < 16; i++) begin
         ref_w[i] = $urandom;
         push_w(ref_w[i]);
      end
      chk("R11 full", 32'(tx_flags), 32'(exp_flags(16, 1'b0, 1'b0)));
      chk("R8 no overrun yet", 32'(err_overrun), 32'd0);
      push_w(32'h1234_5678);
      chk("R8 overrun", 32'(err_overrun), 32'd1);
      wr_ctl(1'b0, 1'b1);
      for (int i = 0; i < 16; i++) begin
         pop_w(w);
         chk("R8 contents", w, ref_w[i]);
      end
      chk("R8 drained", 32'(rx_flags), 32'(exp_flags(0, 1'b0, 1'b1)));

      // R2 clear on enable, R9/R10 with zero length
      wr_len(0);
      wr_ctl(1'b1, 1'b0);
      chk("R2 sticky clear", 32'({err_overrun, err_underrun, data_end}), 32'd0);
      chk("R2 enabled", 32'(eng_en), 32'd1);
      @(negedge clk);
      chk("R9 zero len idle", 32'(eng_en), 32'd0);
      chk("R10 zero len end", 32'({data_end, block_end}), 32'd3);

      // R6 pop only after four bytes leave
      wr_len(8);
      push_w(32'h4433_2211);
      push_w(32'h8877_6655);
      wr_ctl(1'b1, 1'b0);
      repeat (3) @(negedge clk);
      chk("R6 one popped", 32'(tx_flags), 32'(exp_flags(1, 1'b1, 1'b0)));
      for (int k = 0; k < 3; k++) begin
         tx_pulse(b, g);
         chk("R6 first word byte", 32'(b), 32'(8'h11 + 8'(k * 17)));
         chk("R6 no early pop", 32'(tx_flags), 32'(exp_flags(1, 1'b1, 1'b0)));
      end
      tx_pulse(b, g);
      chk("R6 fourth byte", 32'(b), 32'h44);
      @(negedge clk);
      chk("R6 second popped", 32'(tx_flags), 32'(exp_flags(0, 1'b1, 1'b0)));
      for (int k = 0; k < 4; k++) begin
         tx_pulse(b, g);
         chk("R6 second word byte", 32'(b), 32'(8'h55 + 8'(k * 17)));
      end
      @(negedge clk);
      chk("R9 tx idle", 32'(eng_en), 32'd0);

      // directed receive lengths plus constrained random runs
      run_rx(1, 0);
      run_rx(4, 0);
      run_rx(7, 30);
      run_tx(5, 0);
      run_tx(64, 20);
      for (int r = 0; r < 6; r++) begin
         run_rx(1 + int'($urandom % 64), int'($urandom % 60));
         run_tx(1 + int'($urandom % 64), int'($urandom % 60));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule